// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This controller-side sequencer takes a high-speed DRAM from power-on to operation. It waits until `start` arrives. It then waits a programmable supply-settling delay with every device-facing line held low. Next it pulses the serial clock four times while the device reset is low, and then raises reset. It writes only the mode registers flagged as non-default, each one either broadcast or directed. It then issues a power-down exit, two bursts of 128 calibration command pairs, and eight conditioning passes of activate/precharge across all banks.

Register writes and device commands go out as request/acknowledge handshakes. Each step holds its request until the receiving stub acknowledges it. After the last precharge the block pulses `done` for one cycle. It then stays in a maintenance loop that repeats one impedance and one current calibration pair every programmable interval. Only a reset takes it back to idle.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, and while idle or waiting for supplies to settle, `dev_rst`, `ser_clk`, `ser_data`, `sreg_req`, `cmd_req` and `done` are all 0. `ser_data` stays 0 at all times.
- R2: When `start` is sampled high in idle, `ser_clk` first goes high exactly `stable_cycles`+1 cycles later. Exactly four one-cycle high pulses follow, separated by one low cycle, all with `dev_rst` low.
- R3: `dev_rst` rises only after the fourth serial clock pulse has ended. It then stays high until the next reset.
- R4: For every index i, in ascending order, whose `reg_dirty[i]` is 1, exactly one register write goes out with `sreg_addr`=i and `sreg_bcast`=`reg_bcast[i]`. No write goes out for a clear bit, and each request is held until `sreg_ack`.
- R5: Exactly one power-down exit command (`cmd_op`=1) is issued. It comes after all register writes and before any calibration command.
- R6: 128 impedance-calibrate commands (`cmd_op`=2) are issued, each followed at once by a calibrate-end (`cmd_op`=4). Then 128 current-calibrate commands (`cmd_op`=3) are issued, each also followed by a calibrate-end.
- R7: The first maintenance request is raised `cal_interval`+2 cycles after the cycle in which `done` is high. It carries the ops 2, 4, 3, 4 in that order.
- R8: Conditioning runs eight passes. Each pass activates (`cmd_op`=5) banks 0..7 in ascending order and then precharges (`cmd_op`=6) them in the same order. An activate carries `cmd_row` equal to the pass number 0..7. No bank is activated twice without a precharge in between. The totals are 64 activates and 64 precharges.
- R9: `done` is high for exactly one cycle, exactly once per initialization. It follows the acknowledge of the final precharge.
- R10: `start` is ignored whenever the sequencer is not idle.
- R11: While a command request waits for `cmd_ack`, `cmd_req`, `cmd_op`, `cmd_bank` and `cmd_row` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin initialization (accepted only in idle) |
| stable_cycles | input | 16 | Supply-settling delay in cycles |
| cal_interval | input | 16 | Maintenance calibration interval in cycles |
| reg_dirty | input | 8 | One bit per mode register: needs a non-default write |
| reg_bcast | input | 8 | One bit per mode register: write as broadcast |
| dev_rst | output | 1 | Device reset level |
| ser_clk | output | 1 | Device serial clock |
| ser_data | output | 1 | Device serial data (held low by the sequencer) |
| sreg_req | output | 1 | Register write request |
| sreg_addr | output | 3 | Register index of the write |
| sreg_bcast | output | 1 | Broadcast (1) or directed (0) write |
| sreg_ack | input | 1 | Register write accepted |
| cmd_req | output | 1 | Device command request |
| cmd_op | output | 3 | Command code: 1 exit, 2 imp-cal, 3 cur-cal, 4 cal-end, 5 activate, 6 precharge |
| cmd_bank | output | 3 | Bank of an activate/precharge |
| cmd_row | output | 14 | Row of an activate |
| cmd_ack | input | 1 | Command accepted |
| done | output | 1 | One-cycle initialization-complete pulse |

## Verification
The serial clock first rises `stable_cycles`+1 cycles after `start` is taken. The first maintenance request appears `cal_interval`+2 cycles after the `done` cycle. The bench counts falling edges from the stimulus and compares the count with these exact values. Every command or write takes effect on the rising edge after its acknowledge is seen. The bench therefore samples request and acknowledge together at the preceding falling edge, and rebuilds the expected op, bank, row and phase order from how many handshakes it has seen so far. The `done` pulse is checked on the cycle that follows the final precharge handshake.

// File: rtl/init_pkg.sv
// Shared types for the DRAM power-up sequencer.
// Assumes: command codes are fixed; the command stub decodes cmd_op.
package init_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PDX  = 3'd1,
        OP_CALZ = 3'd2,
        OP_CALC = 3'd3,
        OP_CALE = 3'd4,
        OP_ACT  = 3'd5,
        OP_PRE  = 3'd6
    } cmd_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_STABLE, ST_SCK_HI, ST_SCK_LO, ST_RST_UP, ST_REGWR,
        ST_PDX, ST_CALZ, ST_CALC, ST_COND, ST_DONE, ST_PERIOD, ST_PCAL
    } phase_e;

endpackage

// File: rtl/init_delay_timer.sv
// Loadable down-counter shared by the settling delay and the maintenance
// interval. Assumes: load wins over counting; expired is high while the
// count is zero, so a loaded value N expires after N counting cycles.
module init_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // count down from the loaded value, stop at zero
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/init_bank_track.sv
// Per-bank open flag and conditioning pass counter.
// Assumes: act_fire/pre_fire are one-cycle handshake strobes for bank `bank`;
// clr restarts all counters at the start of an initialization.
module init_bank_track #(
    parameter int NBANK  = 8,
    parameter int PASSES = 8,
    localparam int BANK_W = $clog2(NBANK),
    localparam int PASS_W = $clog2(PASSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              act_fire,
    input  logic              pre_fire,
    input  logic [BANK_W-1:0] bank,
    output logic [NBANK-1:0]  open_vec,
    output logic [NBANK-1:0]  full_vec
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [PASS_W-1:0] passes;

        // track open state and completed activates of this bank
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                open_vec[b] <= 1'b0;
                passes      <= '0;
            end else if (act_fire && bank == BANK_W'(b)) begin
                open_vec[b] <= 1'b1;
                passes      <= passes + 1'b1;
            end else if (pre_fire && bank == BANK_W'(b)) begin
                open_vec[b] <= 1'b0;
            end
        end

        assign full_vec[b] = (passes == PASS_W'(PASSES));
    end
endmodule

// File: rtl/dram_init_seq.sv
// Power-up sequencer: settle delay, reset clocking, register writes,
// power-down exit, two calibration bursts, bank conditioning, then a
// periodic calibration loop. Assumes request/acknowledge stubs that hold
// ack for one cycle per accepted request.
module dram_init_seq
    import init_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int NBANK       = 8,
    parameter int ROW_W       = 14,
    parameter int CNT_W       = 16,
    parameter int SCK_PULSES  = 4,
    parameter int CAL_REPS    = 128,
    parameter int COND_PASSES = 8,
    localparam int REG_IW = $clog2(NREG),
    localparam int BANK_W = $clog2(NBANK),
    localparam int SCK_W  = $clog2(SCK_PULSES + 1),
    localparam int CAL_W  = $clog2(CAL_REPS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  stable_cycles,
    input  logic [CNT_W-1:0]  cal_interval,
    input  logic [NREG-1:0]   reg_dirty,
    input  logic [NREG-1:0]   reg_bcast,
    output logic              dev_rst,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              sreg_req,
    output logic [REG_IW-1:0] sreg_addr,
    output logic              sreg_bcast,
    input  logic              sreg_ack,
    output logic              cmd_req,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    input  logic              cmd_ack,
    output logic              done
);
    phase_e            state;
    logic [SCK_W-1:0]  sck_cnt;
    logic [REG_IW-1:0] reg_idx;
    logic [CAL_W-1:0]  cal_cnt;
    logic              half;
    logic [BANK_W-1:0] bank_idx;
    logic [ROW_W-1:0]  row;
    logic [NBANK-1:0]  bank_open, bank_full;
    logic              tmr_load, tmr_exp, cond_ok, cmd_fire, kick;
    logic [CNT_W-1:0]  tmr_val;
    cmd_op_e           op;

    assign kick     = (state == ST_IDLE) && start;
    assign cmd_fire = cmd_req && cmd_ack;
    assign tmr_load = kick || (state == ST_DONE)
                    || (state == ST_PCAL && cmd_fire && cal_cnt[1:0] == 2'd3);
    assign tmr_val  = (state == ST_IDLE) ? stable_cycles : cal_interval;

    init_delay_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_exp)
    );

    init_bank_track #(.NBANK(NBANK), .PASSES(COND_PASSES)) u_track (
        .clk(clk), .rst_n(rst_n), .clr(kick),
        .act_fire(state == ST_COND && cmd_fire && !half),
        .pre_fire(state == ST_COND && cmd_fire && half),
        .bank(bank_idx), .open_vec(bank_open), .full_vec(bank_full)
    );

    // activate only a closed, unfinished bank; precharge only an open one
    assign cond_ok = half ? bank_open[bank_idx]
                          : (!bank_open[bank_idx] && !bank_full[bank_idx]);

    // device pin levels and register-write request
    assign dev_rst    = !(state inside {ST_IDLE, ST_STABLE, ST_SCK_HI, ST_SCK_LO});
    assign ser_clk    = (state == ST_SCK_HI);
    assign ser_data   = 1'b0;
    assign sreg_req   = (state == ST_REGWR) && reg_dirty[reg_idx];
    assign sreg_addr  = reg_idx;
    assign sreg_bcast = reg_bcast[reg_idx];
    assign done       = (state == ST_DONE);
    assign cmd_bank   = bank_idx;
    assign cmd_row    = row;
    assign cmd_op     = op;

    // command code and request per phase
    always_comb begin
        op      = OP_NOP;
        cmd_req = 1'b0;
        unique case (state)
            ST_PDX:  begin op = OP_PDX; cmd_req = 1'b1; end
            ST_CALZ: begin op = half ? OP_CALE : OP_CALZ; cmd_req = 1'b1; end
            ST_CALC: begin op = half ? OP_CALE : OP_CALC; cmd_req = 1'b1; end
            ST_COND: begin op = half ? OP_PRE : OP_ACT; cmd_req = cond_ok; end
            ST_PCAL: begin
                cmd_req = 1'b1;
                unique case (cal_cnt[1:0])
                    2'd0:    op = OP_CALZ;
                    2'd2:    op = OP_CALC;
                    default: op = OP_CALE;
                endcase
            end
            default: ;
        endcase
    end

    // phase sequencing and loop counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sck_cnt  <= '0;
            reg_idx  <= '0;
            cal_cnt  <= '0;
            half     <= 1'b0;
            bank_idx <= '0;
            row      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_STABLE;
                    sck_cnt  <= '0;
                    reg_idx  <= '0;
                    cal_cnt  <= '0;
                    half     <= 1'b0;
                    bank_idx <= '0;
                    row      <= '0;
                end
                ST_STABLE: if (tmr_exp) state <= ST_SCK_HI;
                ST_SCK_HI: state <= ST_SCK_LO;
                ST_SCK_LO: begin
                    if (sck_cnt == SCK_W'(SCK_PULSES - 1)) state <= ST_RST_UP;
                    else begin
                        sck_cnt <= sck_cnt + 1'b1;
                        state   <= ST_SCK_HI;
                    end
                end
                ST_RST_UP: state <= ST_REGWR;
                ST_REGWR: if (!reg_dirty[reg_idx] || sreg_ack) begin
                    if (reg_idx == REG_IW'(NREG - 1)) state <= ST_PDX;
                    else reg_idx <= reg_idx + 1'b1;
                end
                ST_PDX: if (cmd_fire) state <= ST_CALZ;
                ST_CALZ, ST_CALC: if (cmd_fire) begin
                    half <= !half;
                    if (half) begin
                        if (cal_cnt == CAL_W'(CAL_REPS - 1)) begin
                            cal_cnt <= '0;
                            state   <= (state == ST_CALZ) ? ST_CALC : ST_COND;
                        end else cal_cnt <= cal_cnt + 1'b1;
                    end
                end
                ST_COND: if (cmd_fire) begin
                    if (bank_idx == BANK_W'(NBANK - 1)) begin
                        bank_idx <= '0;
                        half     <= !half;
                        if (half) begin
                            if (row == ROW_W'(COND_PASSES - 1)) state <= ST_DONE;
                            else row <= row + 1'b1;
                        end
                    end else bank_idx <= bank_idx + 1'b1;
                end
                ST_DONE:   state <= ST_PERIOD;
                ST_PERIOD: if (tmr_exp) begin
                    state   <= ST_PCAL;
                    cal_cnt <= '0;
                end
                ST_PCAL: if (cmd_fire) begin
                    cal_cnt <= cal_cnt + 1'b1;
                    if (cal_cnt[1:0] == 2'd3) state <= ST_PERIOD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/init_seq_chk.sv
// Protocol checker for the power-up sequencer, attached by bind.
// Assumes the stub interfaces of dram_init_seq and its internal bank tracker.
module init_seq_chk #(
    parameter int NBANK  = 8,
    parameter int ROW_W  = 14,
    parameter int REG_IW = 3,
    localparam int BANK_W = $clog2(NBANK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dev_rst,
    input logic              ser_clk,
    input logic              done,
    input logic              sreg_req,
    input logic              sreg_ack,
    input logic [REG_IW-1:0] sreg_addr,
    input logic              sreg_bcast,
    input logic              cmd_req,
    input logic              cmd_ack,
    input logic [2:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ROW_W-1:0]  cmd_row,
    input logic [NBANK-1:0]  bank_open
);
    // R2
    sclk_rst_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !dev_rst);

    // R3
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> dev_rst);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op)
            && $stable(cmd_bank) && $stable(cmd_row)));

    // R4
    sreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sreg_req && !sreg_ack) |=> (sreg_req && $stable(sreg_addr)
            && $stable(sreg_bcast)));

    // R8
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_ack && cmd_op == 3'd5) |=> bank_open[$past(cmd_bank)]);
endmodule

bind dram_init_seq init_seq_chk #(.NBANK(NBANK), .ROW_W(ROW_W), .REG_IW(REG_IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .ser_clk(ser_clk), .done(done),
    .sreg_req(sreg_req), .sreg_ack(sreg_ack), .sreg_addr(sreg_addr),
    .sreg_bcast(sreg_bcast), .cmd_req(cmd_req), .cmd_ack(cmd_ack),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .bank_open(bank_open)
);

// File: tb/test_dram_init_seq.sv
// Directed bench for dram_init_seq: one task per scenario, each self-checking.
module test_dram_init_seq;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] stable_cycles = '0;
    logic [15:0] cal_interval = 16'd200;
    logic [7:0]  reg_dirty = '0;
    logic [7:0]  reg_bcast = '0;
    logic        dev_rst, ser_clk, ser_data, sreg_req, sreg_bcast, cmd_req, done;
    logic [2:0]  sreg_addr, cmd_op, cmd_bank;
    logic [13:0] cmd_row;
    logic        sreg_ack = 1'b0;
    logic        cmd_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = !clk;

    dram_init_seq i_dram_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .stable_cycles(stable_cycles),
        .cal_interval(cal_interval), .reg_dirty(reg_dirty), .reg_bcast(reg_bcast),
        .dev_rst(dev_rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .sreg_req(sreg_req), .sreg_addr(sreg_addr), .sreg_bcast(sreg_bcast),
        .sreg_ack(sreg_ack), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_ack(cmd_ack), .done(done)
    );

    // stubs: acknowledge every pending request after one wait cycle
    always @(posedge clk) begin
        sreg_ack <= rst_n && sreg_req && !sreg_ack;
        cmd_ack  <= rst_n && cmd_req && !cmd_ack;
    end

    // monitor state, cleared by clear_mon
    int n_sck, rst_at_sck, rst_fall, n_sreg, bc_err, n_pdx, n_calz, n_calc, n_cale;
    int n_act, n_pre, cond_k, cond_err, ord_err, last_ph, data_err, n_done;
    int hold_err, sck_err;
    logic [7:0] seen_mask;
    bit pend, post, sck_prev, rst_prev, wait_prev;
    bit open_b [NB];
    logic [2:0] op_prev, bank_prev;
    logic [13:0] row_prev;

    task automatic clear_mon();
        n_sck = 0; rst_at_sck = -1; rst_fall = 0; n_sreg = 0; bc_err = 0;
        n_pdx = 0; n_calz = 0; n_calc = 0; n_cale = 0; n_act = 0; n_pre = 0;
        cond_k = 0; cond_err = 0; ord_err = 0; last_ph = 0; data_err = 0;
        n_done = 0; hold_err = 0; sck_err = 0; seen_mask = '0; pend = 0;
        post = 0; sck_prev = 0; rst_prev = 0; wait_prev = 0;
        for (int b = 0; b < NB; b++) open_b[b] = 0;
    endtask

    task automatic phase_at(input int ph);
        if (ph < last_ph) ord_err++;
        last_ph = ph;
    endtask

    // observe handshakes at the falling edge, before they complete
    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_data) data_err++;
            if (ser_clk && !sck_prev) begin
                n_sck++;
                if (dev_rst) sck_err++;
            end
            sck_prev = ser_clk;
            if (dev_rst && !rst_prev) rst_at_sck = n_sck;
            if (!dev_rst && rst_prev) rst_fall++;
            rst_prev = dev_rst;
            if (wait_prev && (!cmd_req || cmd_op != op_prev
                              || cmd_bank != bank_prev || cmd_row != row_prev))
                hold_err++;
            wait_prev = cmd_req && !cmd_ack;
            op_prev = cmd_op; bank_prev = cmd_bank; row_prev = cmd_row;
            if (done) begin n_done++; post = 1; end
            if (sreg_req && sreg_ack) begin
                phase_at(3);
                if (seen_mask >= (8'd1 << sreg_addr)) ord_err++;
                seen_mask[sreg_addr] = 1'b1;
                n_sreg++;
                if (sreg_bcast != reg_bcast[sreg_addr]) bc_err++;
            end
            if (cmd_req && cmd_ack && !post) begin
                case (cmd_op)
                    3'd1: begin phase_at(4); n_pdx++; end
                    3'd2: begin phase_at(5); if (pend) ord_err++; pend = 1; n_calz++; end
                    3'd3: begin phase_at(6); if (pend) ord_err++; pend = 1; n_calc++; end
                    3'd4: begin if (!pend) ord_err++; pend = 0; n_cale++; end
                    3'd5, 3'd6: begin
                        phase_at(7);
                        if (cmd_op != (((cond_k / NB) % 2 == 1) ? 3'd6 : 3'd5)) cond_err++;
                        if (int'(cmd_bank) != cond_k % NB) cond_err++;
                        if (cmd_op == 3'd5) begin
                            if (open_b[cmd_bank]) cond_err++;
                            if (int'(cmd_row) != cond_k / (2 * NB)) cond_err++;
                            open_b[cmd_bank] = 1; n_act++;
                        end else begin
                            if (!open_b[cmd_bank]) cond_err++;
                            open_b[cmd_bank] = 0; n_pre++;
                        end
                        cond_k++;
                    end
                    default: ord_err++;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_mon();
        @(negedge clk);
    endtask

    // R1: quiet outputs after reset and while idle
    task automatic t_reset_state();
        do_reset();
        repeat (3) @(negedge clk);
        chk({dev_rst, ser_clk, ser_data, sreg_req, cmd_req, done} == 6'b0,
            "R1 reset state", {dev_rst, ser_clk, ser_data, sreg_req, cmd_req, done}, 0);
    endtask

    // full initialization with one register pattern, stray start mid-run
    task automatic t_full_init(input int stab, input logic [7:0] dirty, input logic [7:0] bc);
        int n;
        stable_cycles = 16'(stab);
        reg_dirty = dirty;
        reg_bcast = bc;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!ser_clk && n < 70000) begin
            chk(!dev_rst && !cmd_req && !sreg_req || n > 0, "R1 settle quiet", dev_rst, 0);
            n++; @(negedge clk);
        end
        chk(n == stab + 1, "R2 settle delay", n, stab + 1);
        repeat (40) @(negedge clk);
        start = 1'b1;   // R10: must be ignored
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 20000) begin n++; @(negedge clk); end
        chk(done, "R9 done reached", done, 1);
        chk(n_sck == 4 && sck_err == 0, "R2 four clock pulses, reset low", n_sck, 4);
        chk(rst_at_sck == 4 && rst_fall == 0, "R3 reset after fourth pulse", rst_at_sck, 4);
        chk(n_sreg == $countones(dirty) && seen_mask == dirty, "R4 dirty writes",
            seen_mask, dirty);
        chk(bc_err == 0, "R4 broadcast flag", bc_err, 0);
        chk(n_pdx == 1, "R5 one power-down exit", n_pdx, 1);
        chk(n_calz == 128 && n_calc == 128 && n_cale == 256, "R6 calibration counts",
            n_calz + n_calc + n_cale, 512);
        chk(ord_err == 0 && !pend, "R5 R6 phase order", ord_err, 0);
        chk(n_act == 64 && n_pre == 64 && cond_err == 0, "R8 conditioning", n_act + n_pre
            + 1000 * cond_err, 128);
        chk(n_sck == 4 && n_pdx == 1 && n_calz == 128, "R10 stray start ignored", n_sck, 4);
        chk(hold_err == 0, "R11 request held until ack", hold_err, 0);
        chk(data_err == 0, "R1 serial data low", data_err, 0);
    endtask

    // R7: periodic calibration timing and order; R9 single done
    task automatic t_periodic();
        int n;
        logic [2:0] ops [4];
        n = 0;
        do begin @(negedge clk); n++; end while (!cmd_req && n < 70000);
        chk(n == int'(cal_interval) + 2, "R7 interval to first request", n,
            int'(cal_interval) + 2);
        for (int k = 0; k < 4; k++) begin
            while (!(cmd_req && cmd_ack)) @(negedge clk);
            ops[k] = cmd_op;
            @(negedge clk);
        end
        chk({ops[0], ops[1], ops[2], ops[3]} == {3'd2, 3'd4, 3'd3, 3'd4},
            "R7 maintenance order", {ops[0], ops[1], ops[2], ops[3]}, 12'o2434);
        chk(n_done == 1 && !done, "R9 done single pulse", n_done, 1);
    endtask

    initial begin
        t_reset_state();
        t_full_init(5, 8'b1010_0101, 8'b0000_0101);
        t_periodic();
        do_reset();
        t_full_init(0, 8'h00, 8'h00);
        do_reset();
        cal_interval = 16'd37;
        t_full_init(3, 8'hFF, 8'hF0);
        t_periodic();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog: a hung run ends as a failure
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule